// File: doc/BRIEF.md
# Fetch-Stage Next-PC Predictor

This block chooses the address the fetch stage will use on the next cycle. Three candidates compete: the address of the following word (current PC plus four), a branch target remembered from earlier execution, and a corrected address sent back by the execution stages when a prediction turns out wrong. A correction always wins and also produces a flush pulse that clears the register between fetch and decode.

Two independent tables drive the prediction. The first is a small direct-mapped cache of branch targets, tagged by fetch address. The second is a table of two-bit saturating counters, indexed by the low word-address bits of the PC. A branch is predicted taken only when the target cache holds a matching entry and the counter's upper bit is set. When the target cache misses, the block predicts not-taken, whatever the counter says.

Resolved branches come back through an update port carrying the branch PC, its outcome and its real target. Lookups are combinational on the current PC and read the table contents from before the edge. Updates are written at the clock edge.

Top module: `npc_predictor`

## Requirements
- R1: After synchronous reset, every target entry is invalid and every counter holds weakly not-taken (01). Every lookup then yields PC+4 with the taken flag low.
- R2: When the correction input is valid, next PC equals the correction address, flush is 1 and the taken flag is 0 in that same cycle, whatever the tables hold.
- R3: Flush is 0 in every cycle in which no correction is presented.
- R4: If the target cache has no valid entry whose tag matches the current PC, next PC is PC+4 and the taken flag is 0, even when the counter's upper bit is 1.
- R5: If the target cache hits and the indexed counter's upper bit is 1, next PC is the stored target and the taken flag is 1.
- R6: If the target cache hits and the counter's upper bit is 0, next PC is PC+4 and the taken flag is 0.
- R7: Each update moves the counter at the branch's index up by one on taken and down by one on not-taken, saturating at 00 and 11. A single not-taken outcome from 11 leaves the prediction taken.
- R8: With the default sizes the counter index is PC bits [7:2] and the target index is PC bits [5:2], with PC bits [31:6] as the tag. PCs that share index bits share the entry, and a differing tag misses.
- R9: A taken update writes valid, tag and target into its target entry and replaces any previous occupant. A not-taken update leaves the target cache unchanged.
- R10: An update takes effect from the following cycle. A lookup of the same entry in the update's own cycle sees the old contents.
- R11: The sequential address is PC+4 modulo 2^32 (0xFFFFFFFC gives 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc_i | input | 32 | Address being fetched this cycle |
| upd_valid_i | input | 1 | A resolved branch is reported this cycle |
| upd_pc_i | input | 32 | Address of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome of the resolved branch |
| upd_target_i | input | 32 | Actual target of the resolved branch |
| fix_valid_i | input | 1 | Misprediction recovery request |
| fix_pc_i | input | 32 | Correct address to fetch from |
| next_pc_o | output | 32 | Address chosen for the next fetch |
| pred_taken_o | output | 1 | Chosen address is a predicted branch target |
| flush_o | output | 1 | Clear the fetch/decode register |

## Verification
The hardest situation to reach from the ports is a counter already predicting taken on a PC whose target entry belongs to a different branch. Here the counter alone would redirect fetch, but the tag mismatch must keep the sequential address. The stimulus reaches it by training one branch to the saturated state, then fetching an address 256 bytes away that aliases both index fields with a different tag, and finally allocating that alias so it evicts the first branch. A random phase over a small pool of aliasing addresses, with mixed updates and corrections, then reaches same-cycle update and lookup collisions many times.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_e;

    typedef enum logic [1:0] {
        SRC_SEQ,
        SRC_TGT,
        SRC_FIX
    } src_e;

    function automatic ctr_e ctr_step(ctr_e cur, logic taken);
        ctr_e nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_STRONG_T) nxt = ctr_e'(cur + 2'd1);
        end else begin
            if (cur != CTR_STRONG_NT) nxt = ctr_e'(cur - 2'd1);
        end
        return nxt;
    endfunction

    function automatic logic ctr_leans_taken(ctr_e c);
        return c[1];
    endfunction

endpackage

// File: rtl/npc_history.sv
module npc_history
    import npc_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    ctr_e tbl [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) tbl[i] <= CTR_WEAK_NT;
        end else if (wr_en) begin
            tbl[wr_idx] <= ctr_step(tbl[wr_idx], wr_taken);
        end
    end

    assign rd_taken = ctr_leans_taken(tbl[rd_idx]);

    // R7
    ctr_hold_high_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken && tbl[wr_idx] == CTR_STRONG_T)
        |=> tbl[$past(wr_idx)] == CTR_STRONG_T);

    // R7
    ctr_hold_low_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken && tbl[wr_idx] == CTR_STRONG_NT)
        |=> tbl[$past(wr_idx)] == CTR_STRONG_NT);

    // R7
    ctr_loop_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken && tbl[wr_idx] == CTR_STRONG_T)
        |=> tbl[$past(wr_idx)] == CTR_WEAK_T);

endmodule

// File: rtl/npc_target_cache.sv
module npc_target_cache #(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int TAG_W  = ADDR_W - IDX_W - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_hit,
    output logic [ADDR_W-1:0] rd_target,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_target
);
    logic              vld [ENTRIES];
    logic [TAG_W-1:0]  tag [ENTRIES];
    logic [ADDR_W-1:0] tgt [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                vld[i] <= 1'b0;
                tag[i] <= '0;
                tgt[i] <= '0;
            end
        end else if (wr_en) begin
            vld[wr_idx] <= 1'b1;
            tag[wr_idx] <= wr_tag;
            tgt[wr_idx] <= wr_target;
        end
    end

    assign rd_hit    = vld[rd_idx] && (tag[rd_idx] == rd_tag);
    assign rd_target = tgt[rd_idx];

    // R9
    alloc_fill_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (vld[$past(wr_idx)] && tag[$past(wr_idx)] == $past(wr_tag)
                   && tgt[$past(wr_idx)] == $past(wr_target)));

endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic              tgt_hit,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic              dir_taken,
    input  logic              fix_valid,
    input  logic [ADDR_W-1:0] fix_pc,
    output logic [ADDR_W-1:0] next_pc,
    output logic              pred_taken,
    output logic              flush
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    src_e src;

    always_comb begin
        if (fix_valid)                 src = SRC_FIX;
        else if (tgt_hit && dir_taken) src = SRC_TGT;
        else                           src = SRC_SEQ;
    end

    always_comb begin
        unique case (src)
            SRC_FIX: next_pc = fix_pc;
            SRC_TGT: next_pc = tgt_addr;
            default: next_pc = pc + STEP;
        endcase
    end

    assign pred_taken = (src == SRC_TGT);
    assign flush      = (src == SRC_FIX);

endmodule

// File: rtl/npc_predictor.sv
module npc_predictor
    import npc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int TC_ENTRIES = 16,
    parameter int HT_ENTRIES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] fetch_pc_i,
    input  logic              upd_valid_i,
    input  logic [ADDR_W-1:0] upd_pc_i,
    input  logic              upd_taken_i,
    input  logic [ADDR_W-1:0] upd_target_i,
    input  logic              fix_valid_i,
    input  logic [ADDR_W-1:0] fix_pc_i,
    output logic [ADDR_W-1:0] next_pc_o,
    output logic              pred_taken_o,
    output logic              flush_o
);
    localparam int TC_IDX_W = $clog2(TC_ENTRIES);
    localparam int HT_IDX_W = $clog2(HT_ENTRIES);
    localparam int TAG_W    = ADDR_W - TC_IDX_W - 2;

    logic              tc_hit;
    logic [ADDR_W-1:0] tc_target;
    logic              ht_taken;
    logic [1:0]        unused_low;

    assign unused_low = upd_pc_i[1:0];

    npc_target_cache #(.ADDR_W(ADDR_W), .ENTRIES(TC_ENTRIES)) u_tcache (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (fetch_pc_i[TC_IDX_W+1:2]),
        .rd_tag    (fetch_pc_i[ADDR_W-1:TC_IDX_W+2]),
        .rd_hit    (tc_hit),
        .rd_target (tc_target),
        .wr_en     (upd_valid_i && upd_taken_i),
        .wr_idx    (upd_pc_i[TC_IDX_W+1:2]),
        .wr_tag    (upd_pc_i[ADDR_W-1:TC_IDX_W+2]),
        .wr_target (upd_target_i)
    );

    npc_history #(.ENTRIES(HT_ENTRIES)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (fetch_pc_i[HT_IDX_W+1:2]),
        .rd_taken (ht_taken),
        .wr_en    (upd_valid_i),
        .wr_idx   (upd_pc_i[HT_IDX_W+1:2]),
        .wr_taken (upd_taken_i)
    );

    npc_select #(.ADDR_W(ADDR_W)) u_sel (
        .pc         (fetch_pc_i),
        .tgt_hit    (tc_hit),
        .tgt_addr   (tc_target),
        .dir_taken  (ht_taken),
        .fix_valid  (fix_valid_i),
        .fix_pc     (fix_pc_i),
        .next_pc    (next_pc_o),
        .pred_taken (pred_taken_o),
        .flush      (flush_o)
    );

    // R2
    fix_wins_chk: assert property (@(posedge clk) disable iff (rst)
        fix_valid_i |-> (next_pc_o == fix_pc_i && flush_o && !pred_taken_o));

    // R3
    no_stray_flush_chk: assert property (@(posedge clk) disable iff (rst)
        !fix_valid_i |-> !flush_o);

    // R4
    miss_not_taken_chk: assert property (@(posedge clk) disable iff (rst)
        !tc_hit |-> !pred_taken_o);

    // R5
    taken_uses_target_chk: assert property (@(posedge clk) disable iff (rst)
        pred_taken_o |-> (next_pc_o == tc_target && ht_taken));

endmodule

// File: tb/test_npc_predictor.sv
module test_npc_predictor;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_pc = '0;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;
    logic        fix_valid = 1'b0;
    logic [31:0] fix_pc = '0;
    logic [31:0] next_pc;
    logic        pred_taken;
    logic        flush;

    int checks = 0;
    int errors = 0;

    // Behavioural reference state
    int          m_ctr [64];
    bit          m_vld [16];
    logic [31:0] m_bpc [16];
    logic [31:0] m_tgt [16];

    always #4 clk = ~clk;

    npc_predictor i_npc_predictor (
        .clk(clk), .rst(rst), .fetch_pc_i(fetch_pc),
        .upd_valid_i(upd_valid), .upd_pc_i(upd_pc), .upd_taken_i(upd_taken),
        .upd_target_i(upd_target), .fix_valid_i(fix_valid), .fix_pc_i(fix_pc),
        .next_pc_o(next_pc), .pred_taken_o(pred_taken), .flush_o(flush)
    );

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary();
    end

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 64; i++) m_ctr[i] = 1;
        for (int i = 0; i < 16; i++) begin
            m_vld[i] = 0; m_bpc[i] = '0; m_tgt[i] = '0;
        end
    endtask

    // One cycle: drive, compare against the model, clock, advance the model.
    task automatic cycle(input logic [31:0] pc, input bit uv, input logic [31:0] upc,
                         input bit ut, input logic [31:0] utg, input bit fv,
                         input logic [31:0] fpc, input string tag);
        bit          hit;
        bit          e_t;
        logic [31:0] e_pc;
        string       req;
        @(negedge clk);
        fetch_pc = pc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
        upd_target = utg; fix_valid = fv; fix_pc = fpc;
        #1;
        hit  = m_vld[pc[5:2]] && (m_bpc[pc[5:2]][31:2] == pc[31:2]);
        e_t  = !fv && hit && (m_ctr[pc[7:2]] >= 2);
        e_pc = fv ? fpc : (e_t ? m_tgt[pc[5:2]] : pc + 32'd4);
        if (tag != "")   req = tag;
        else if (fv)     req = "R2";
        else if (!hit)   req = "R4";
        else if (e_t)    req = "R5";
        else             req = "R6";
        chk(next_pc === e_pc, req, "next_pc", next_pc, e_pc);
        chk(pred_taken === e_t, req, "pred_taken", {31'd0, pred_taken}, {31'd0, e_t});
        chk(flush === fv, fv ? "R2" : "R3", "flush", {31'd0, flush}, {31'd0, fv});
        @(posedge clk);
        if (uv) begin
            if (ut && m_ctr[upc[7:2]] < 3) m_ctr[upc[7:2]]++;
            if (!ut && m_ctr[upc[7:2]] > 0) m_ctr[upc[7:2]]--;
            if (ut) begin
                m_vld[upc[5:2]] = 1; m_bpc[upc[5:2]] = upc; m_tgt[upc[5:2]] = utg;
            end
        end
    endtask

    task automatic look(input logic [31:0] pc, input string tag);
        cycle(pc, 0, '0, 0, '0, 0, '0, tag);
    endtask

    task automatic train(input logic [31:0] bpc, input bit t, input logic [31:0] tg,
                         input logic [31:0] pc, input string tag);
        cycle(pc, 1, bpc, t, tg, 0, '0, tag);
    endtask

    localparam logic [31:0] BR_X  = 32'h0000_1040;
    localparam logic [31:0] TG_Y  = 32'h0000_2000;
    localparam logic [31:0] BR_Z  = 32'h0000_1140;  // same [7:2] and [5:2], other tag
    localparam logic [31:0] TG_W  = 32'h0000_3300;

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1: empty tables after reset
        look(BR_X, "R1");
        look(32'h0000_0000, "R1");
        look(32'h8000_0ABC, "R1");
        // R9: a not-taken update allocates nothing (counter 01 -> 00)
        train(BR_X, 0, TG_Y, 32'h0000_0100, "R9");
        look(BR_X, "R9");
        // R10: taken update while the same PC is looked up sees old contents
        train(BR_X, 1, TG_Y, BR_X, "R10");
        // R6: entry present, counter now 01
        look(BR_X, "R6");
        // R5: counter to 10, then predicted taken
        train(BR_X, 1, TG_Y, 32'h0000_0200, "R7");
        look(BR_X, "R5");
        // R7: saturate at 11, one not-taken keeps the taken prediction
        train(BR_X, 1, TG_Y, 32'h0000_0200, "R7");
        train(BR_X, 1, TG_Y, 32'h0000_0200, "R7");
        train(BR_X, 1, TG_Y, 32'h0000_0200, "R7");
        train(BR_X, 0, TG_Y, 32'h0000_0200, "R7");
        look(BR_X, "R7");
        // R8 / R4: alias shares counter (taken) but tag differs -> sequential
        look(BR_Z, "R8");
        look(BR_Z, "R4");
        // R9: taken alias overwrites the entry; X now misses, Z hits
        train(BR_Z, 1, TG_W, 32'h0000_0300, "R9");
        look(BR_X, "R9");
        look(BR_Z, "R8");
        // R2: correction wins over a hitting taken prediction
        cycle(BR_Z, 0, '0, 0, '0, 1, 32'h0000_4444, "R2");
        look(BR_Z, "R3");
        // R11: sequential wrap
        look(32'hFFFF_FFFC, "R11");
        // R7: drive a counter down to 00 and hold it there
        for (int i = 0; i < 5; i++) train(BR_Z, 0, TG_W, 32'h0000_0500, "R7");
        look(BR_Z, "R7");
        train(BR_Z, 1, TG_W, 32'h0000_0500, "R7");
        look(BR_Z, "R6");
        // Random mix over an aliasing address pool
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] pool [8];
            logic [31:0] p, u;
            pool = '{32'h0000_1040, 32'h0000_1140, 32'h0000_1080, 32'h0000_2040,
                     32'h0000_1044, 32'h0000_10C0, 32'hFFFF_FFFC, 32'h0000_0000};
            p = pool[$urandom_range(0, 7)];
            u = pool[$urandom_range(0, 7)];
            cycle(p, ($urandom_range(0, 1) == 1), u, ($urandom_range(0, 2) != 0),
                  $urandom & 32'hFFFF_FFFC, ($urandom_range(0, 9) == 0),
                  $urandom & 32'hFFFF_FFFC, "");
        end
        summary();
    end
endmodule